// File: doc/BRIEF.md
# Command-Driven Two-Wire Serial Memory Master

This block is a byte-level master for a two-wire serial memory bus. A processor steers it through a 4-bit command field, an 8-bit data register and a status nibble. Each accepted command produces exactly one bus primitive: a start condition, a stop condition, one transmitted byte, or one received byte. After a received byte the master either acknowledges it or leaves the acknowledge slot released. The processor builds a full memory transaction by issuing these primitives one after another, and it waits for the busy flag to fall or for the one-cycle interrupt between them.

The serial clock comes from a divider of the system clock. Each bit slot is four quarter periods long. SCK is low in the first half of a slot and high in the second half. SDA is driven as an open-drain line: an output enable pulls it low, and the pin level comes back in on a separate input. The master moves SDA a quarter period after SCK falls and samples it a quarter period after SCK rises. Once the clock has started it keeps running between commands. Only the idle command parks it high. Any undefined command code does nothing on the bus and raises a sticky error flag.

Top module: `twi_cmd_master`

## Requirements
- R1: After reset the status nibble `ctl_rdata[7:4]` reads 4'b0011. Bit 7 is the error flag, bit 6 is busy, bit 5 is the slave-acknowledge flag and bit 4 is the master-acknowledge flag. `ctl_rdata[3:0]` always reads 0. SCK is high, SDA is released and `irq` is low.
- R2: Command 4'b1001 occupies one bit slot and releases SDA, then pulls it low while SCK is high (a start condition). When issued with the clock parked, busy stays high for 1 + 4·Q cycles.
- R3: Command 4'b0101 occupies one bit slot and pulls SDA low, then releases it while SCK is high (a stop condition).
- R4: Command 4'b0011 sends the data register MSB first over eight slots and releases SDA in the ninth slot. During a byte transfer SDA never changes while SCK is high. When issued with the clock parked, busy stays high for 1 + 36·Q cycles.
- R5: At the end of a transmit, status bit 5 holds the SDA level sampled in the ninth slot: 0 means the slave acknowledged and 1 means it did not.
- R6: Command 4'b0001 shifts eight SDA samples, MSB first, into the data register. The master pulls SDA low in the ninth slot and status bit 4 becomes 0.
- R7: Command 4'b0110 receives a byte the same way, but leaves SDA released in the ninth slot, and status bit 4 becomes 1.
- R8: `irq` is high for exactly one cycle, in the first cycle where busy reads 0 after an operation. Busy rises only after an accepted command write.
- R9: Every code other than 0000, 0001, 0011, 0101, 0110 and 1001 causes no bus activity and sets status bit 7. The flag stays set until a valid command, including 0000, is accepted.
- R10: Command 4'b0000 stops SCK and holds it high. Without it, SCK keeps toggling after an operation ends.
- R11: Command and data writes presented while busy is 1 have no effect.
- R12: One quarter of an SCK period is Q = CLK_HZ / (4·SCK_HZ) system cycles, with a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the command field |
| ctl_cmd | input | 4 | Command code |
| ctl_rdata | output | 8 | Status: {error, busy, slave-ack flag, master-ack flag, 4'b0} |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Data register (received byte after a receive) |
| irq | output | 1 | One-cycle completion pulse |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA pin level |

## Verification
The assertions assume that `sda_i` reflects the wired-AND of the master and the slave. They also assume that the slave only moves SDA while SCK is low, so any SDA edge seen during a high SCK is one the master made. The bench's responder follows this rule: it changes its line only on falling SCK edges and reads it on rising edges. Strobes are driven on falling system-clock edges, so each command is seen in exactly one cycle.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

  // Command codes; the values are decoded by software and must not move.
  localparam logic [3:0] CMD_IDLE    = 4'b0000;
  localparam logic [3:0] CMD_RD_ACK  = 4'b0001;
  localparam logic [3:0] CMD_WR      = 4'b0011;
  localparam logic [3:0] CMD_STOP    = 4'b0101;
  localparam logic [3:0] CMD_RD_LAST = 4'b0110;
  localparam logic [3:0] CMD_START   = 4'b1001;

  typedef enum logic [2:0] {
    OP_START,
    OP_STOP,
    OP_WR,
    OP_RD_ACK,
    OP_RD_LAST
  } op_e;

  function automatic logic code_valid(input logic [3:0] c);
    return (c == CMD_IDLE) || (c == CMD_RD_ACK) || (c == CMD_WR) ||
           (c == CMD_STOP) || (c == CMD_RD_LAST) || (c == CMD_START);
  endfunction

  function automatic op_e code_to_op(input logic [3:0] c);
    case (c)
      CMD_START:   return OP_START;
      CMD_STOP:    return OP_STOP;
      CMD_WR:      return OP_WR;
      CMD_RD_ACK:  return OP_RD_ACK;
      default:     return OP_RD_LAST;
    endcase
  endfunction

  // System cycles per quarter of an SCK period.
  function automatic int unsigned quarter_cycles(input int unsigned clk_hz,
                                                 input int unsigned sck_hz);
    int unsigned q;
    q = clk_hz / (4 * sck_hz);
    if (q < 2) q = 2;
    return q;
  endfunction

  // Index of the final bit slot of an operation.
  function automatic logic [3:0] last_slot(input op_e op);
    return (op == OP_START || op == OP_STOP) ? 4'd0 : 4'd8;
  endfunction

endpackage

// File: rtl/twi_sck_phase.sv
module twi_sck_phase #(
  parameter int unsigned QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic park_i,
  output logic run_o,
  output logic scl_o,
  output logic slot_end_o,
  output logic low_mid_o,
  output logic high_mid_o
);
  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  logic          run;
  logic          qtick;

  assign qtick = run && (cnt == CW'(QDIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= 2'd0;
    end else if (park_i) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= 2'd0;
    end else if (start_i && !run) begin
      // Preload so the very next cycle closes a slot and SCK falls.
      run   <= 1'b1;
      cnt   <= CW'(QDIV - 1);
      phase <= 2'd3;
    end else if (run) begin
      if (qtick) begin
        cnt   <= '0;
        phase <= phase + 2'd1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign run_o      = run;
  assign scl_o      = run ? phase[1] : 1'b1;
  assign slot_end_o = qtick && (phase == 2'd3);
  assign low_mid_o  = qtick && (phase == 2'd0);
  assign high_mid_o = qtick && (phase == 2'd2);

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  op_e        op_i,
  input  logic [7:0] wdata_i,
  input  logic       slot_end_i,
  input  logic       low_mid_i,
  input  logic       high_mid_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       sda_oe_o,
  output logic [7:0] rd_byte_o,
  output logic       rd_load_o,
  output logic       rx_nack_o,
  output logic       tx_nack_o,
  output logic       byte_xfer_o
);
  logic       busy, started, sda_low, done, rd_load, rx_nack, tx_nack;
  op_e        op;
  logic [3:0] slot;
  logic [7:0] shreg;
  logic       drive_low;
  logic       is_read;

  assign is_read = (op == OP_RD_ACK) || (op == OP_RD_LAST);

  // Level the master wants on SDA for the current slot (1 = pull low).
  always_comb begin
    case (op)
      OP_START:  drive_low = 1'b0;
      OP_STOP:   drive_low = 1'b1;
      OP_WR:     drive_low = (slot < 4'd8) ? ~shreg[3'd7 - slot[2:0]] : 1'b0;
      OP_RD_ACK: drive_low = (slot == 4'd8);
      default:   drive_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      started <= 1'b0;
      op      <= OP_START;
      slot    <= 4'd0;
      shreg   <= 8'h00;
      sda_low <= 1'b0;
      done    <= 1'b0;
      rd_load <= 1'b0;
      rx_nack <= 1'b1;
      tx_nack <= 1'b1;
    end else begin
      done    <= 1'b0;
      rd_load <= 1'b0;
      if (go_i) begin
        busy    <= 1'b1;
        started <= 1'b0;
        op      <= op_i;
        slot    <= 4'd0;
        shreg   <= wdata_i;
      end else if (busy) begin
        if (slot_end_i) begin
          if (!started) begin
            started <= 1'b1;
            slot    <= 4'd0;
          end else if (slot == last_slot(op)) begin
            busy    <= 1'b0;
            started <= 1'b0;
            done    <= 1'b1;
            if (is_read) begin
              rd_load <= 1'b1;
              tx_nack <= (op == OP_RD_LAST);
            end
          end else begin
            slot <= slot + 4'd1;
          end
        end
        if (low_mid_i && started) sda_low <= drive_low;
        if (high_mid_i && started) begin
          case (op)
            OP_START: sda_low <= 1'b1;
            OP_STOP:  sda_low <= 1'b0;
            OP_WR:    if (slot == 4'd8) rx_nack <= sda_i;
            default:  if (slot < 4'd8) shreg <= {shreg[6:0], sda_i};
          endcase
        end
      end
    end
  end

  assign busy_o      = busy;
  assign done_o      = done;
  assign sda_oe_o    = sda_low;
  assign rd_byte_o   = shreg;
  assign rd_load_o   = rd_load;
  assign rx_nack_o   = rx_nack;
  assign tx_nack_o   = tx_nack;
  assign byte_xfer_o = busy && started && (op == OP_WR || is_read);

endmodule

// File: rtl/twi_cmd_master.sv
module twi_cmd_master
  import twi_cmd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned SCK_HZ = 78_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_cmd,
  output logic [7:0] ctl_rdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic       irq,
  output logic       scl_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  localparam int unsigned QDIV = quarter_cycles(CLK_HZ, SCK_HZ);

  logic       busy, cmd_take, cmd_ok, cmd_idle, go, park;
  logic       clk_run, slot_end, low_mid, high_mid;
  logic       rd_load, rx_nack, tx_nack, byte_xfer;
  logic [7:0] rd_byte, data_q;
  logic       err;

  assign cmd_take = ctl_wr && !busy;
  assign cmd_ok   = code_valid(ctl_cmd);
  assign cmd_idle = (ctl_cmd == CMD_IDLE);
  assign go       = cmd_take && cmd_ok && !cmd_idle;
  assign park     = cmd_take && cmd_idle;

  twi_sck_phase #(.QDIV(QDIV)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (go),
    .park_i     (park),
    .run_o      (clk_run),
    .scl_o      (scl_o),
    .slot_end_o (slot_end),
    .low_mid_o  (low_mid),
    .high_mid_o (high_mid)
  );

  twi_byte_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .op_i        (code_to_op(ctl_cmd)),
    .wdata_i     (data_q),
    .slot_end_i  (slot_end),
    .low_mid_i   (low_mid),
    .high_mid_i  (high_mid),
    .sda_i       (sda_i),
    .busy_o      (busy),
    .done_o      (irq),
    .sda_oe_o    (sda_oe_o),
    .rd_byte_o   (rd_byte),
    .rd_load_o   (rd_load),
    .rx_nack_o   (rx_nack),
    .tx_nack_o   (tx_nack),
    .byte_xfer_o (byte_xfer)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      data_q <= 8'h00;
    end else begin
      if (cmd_take) err <= !cmd_ok;
      if (rd_load) data_q <= rd_byte;
      else if (dat_wr && !busy) data_q <= dat_wdata;
    end
  end

  assign ctl_rdata = {err, busy, rx_nack, tx_nack, 4'b0000};
  assign dat_rdata = data_q;

endmodule

// File: rtl/twi_cmd_master_chk.sv
module twi_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [3:0] ctl_cmd,
  input logic       busy,
  input logic       err,
  input logic       irq,
  input logic       scl_o,
  input logic       sda_oe_o,
  input logic       clk_run,
  input logic       byte_xfer
);

  assert_irq_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  assert_fall_gives_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_busy_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctl_wr));

  assert_sda_quiet_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_xfer && $past(byte_xfer) && scl_o && $past(scl_o)) |-> $stable(sda_oe_o));

  assert_scl_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run |-> scl_o);

  assert_bad_code_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy && !(ctl_cmd inside {4'h0, 4'h1, 4'h3, 4'h5, 4'h6, 4'h9}))
      |=> (err && !busy));

  assert_busy_locks_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(err));

endmodule

bind twi_cmd_master twi_cmd_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_cmd   (ctl_cmd),
  .busy      (busy),
  .err       (err),
  .irq       (irq),
  .scl_o     (scl_o),
  .sda_oe_o  (sda_oe_o),
  .clk_run   (clk_run),
  .byte_xfer (byte_xfer)
);

// File: tb/twi_cmd_master_bench.sv
module twi_cmd_master_bench;
  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned SCK_HZ = 10_000_000;
  localparam int Q = 5;  // R12: 200e6 / (4 * 10e6)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [3:0] ctl_cmd = 4'h0;
  logic [7:0] ctl_rdata;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = 8'h00;
  logic [7:0] dat_rdata;
  logic       irq, scl, sda_oe;
  logic       sl_low = 1'b0;
  wire        sda_bus = !(sda_oe || sl_low);

  int tests = 0, fails = 0;
  int irq_cnt = 0, busy_cyc = 0, start_cnt = 0, stop_cnt = 0, scl_rises = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  twi_cmd_master #(.CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ)) u_twi_cmd_master (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cmd(ctl_cmd),
    .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .irq(irq), .scl_o(scl), .sda_oe_o(sda_oe),
    .sda_i(sda_bus)
  );

  wire busy = ctl_rdata[6];

  always @(negedge clk) begin
    if (irq === 1'b1) irq_cnt++;
    if (busy === 1'b1) busy_cyc++;
  end
  always @(negedge sda_bus) if (rst_n && scl === 1'b1) start_cnt++;
  always @(posedge sda_bus) if (rst_n && scl === 1'b1) stop_cnt++;
  always @(posedge scl) if (rst_n) scl_rises++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [3:0] c);
    @(negedge clk); ctl_wr = 1'b1; ctl_cmd = c;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] d);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = d;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  // Slave model: rd_mode=1 sends 'byt'; otherwise it ACKs in slot 8 when 'ack'.
  task automatic respond(input bit rd_mode, input logic [7:0] byt, input bit ack,
                         output logic [8:0] got);
    got = '0;
    @(negedge scl);
    for (int s = 0; s < 9; s++) begin
      if (rd_mode) sl_low = (s < 8) ? !byt[7 - s] : 1'b0;
      else         sl_low = (s == 8) ? ack : 1'b0;
      @(posedge scl);
      got = {got[7:0], sda_bus};
      @(negedge scl);
    end
    sl_low = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ctl_rdata == 8'h30, "R1 status", ctl_rdata, 8'h30);
    chk(scl === 1'b1 && sda_oe === 1'b0 && irq === 1'b0, "R1 pins",
        {scl, sda_oe, irq}, 3'b100);
  endtask

  task automatic t_start_parked();
    int i0 = irq_cnt, b0 = busy_cyc, s0 = start_cnt, p0 = stop_cnt;
    put_cmd(4'b1001);
    settle();
    chk(busy_cyc - b0 == 1 + 4 * Q, "R2 R12 start duration", busy_cyc - b0, 1 + 4 * Q);
    chk(start_cnt - s0 == 1 && stop_cnt == p0, "R2 start condition", start_cnt - s0, 1);
    chk(irq_cnt - i0 == 1, "R8 one irq", irq_cnt - i0, 1);
  endtask

  task automatic t_write(input logic [7:0] d, input bit ack);
    logic [8:0] got;
    int i0 = irq_cnt, b0 = busy_cyc, s0 = start_cnt, p0 = stop_cnt;
    put_data(d);
    put_cmd(4'b0011);
    respond(1'b0, 8'h00, ack, got);
    settle();
    chk(got[8:1] == d, "R4 bits on bus", got[8:1], d);
    chk(got[0] == !ack, "R4 slot 8 level", got[0], !ack);
    chk(start_cnt == s0 && stop_cnt == p0, "R4 no sda edge with scl high",
        start_cnt - s0 + stop_cnt - p0, 0);
    chk(ctl_rdata[5] == !ack, "R5 slave ack flag", ctl_rdata[5], !ack);
    chk(busy_cyc - b0 > 36 * Q && busy_cyc - b0 <= 40 * Q, "R4 write duration",
        busy_cyc - b0, 36 * Q);
    chk(irq_cnt - i0 == 1, "R8 one irq", irq_cnt - i0, 1);
  endtask

  task automatic t_read(input logic [7:0] d, input bit last);
    logic [8:0] got;
    int i0 = irq_cnt;
    put_cmd(last ? 4'b0110 : 4'b0001);
    respond(1'b1, d, 1'b0, got);
    settle();
    if (last) begin
      chk(dat_rdata == d, "R7 byte", dat_rdata, d);
      chk(got[0] == 1'b1, "R7 slot 8 released", got[0], 1);
      chk(ctl_rdata[4] == 1'b1, "R7 master ack flag", ctl_rdata[4], 1);
    end else begin
      chk(dat_rdata == d, "R6 byte", dat_rdata, d);
      chk(got[0] == 1'b0, "R6 slot 8 pulled low", got[0], 0);
      chk(ctl_rdata[4] == 1'b0, "R6 master ack flag", ctl_rdata[4], 0);
    end
    chk(irq_cnt - i0 == 1, "R8 one irq", irq_cnt - i0, 1);
  endtask

  task automatic t_stop();
    int p0 = stop_cnt;
    put_cmd(4'b0101);
    settle();
    chk(stop_cnt - p0 == 1, "R3 stop condition", stop_cnt - p0, 1);
  endtask

  task automatic t_clock_modes();
    int r0 = scl_rises;
    repeat (100) @(negedge clk);
    chk(scl_rises - r0 >= 4, "R10 scl keeps running", scl_rises - r0, 5);
    put_cmd(4'b0000);
    r0 = scl_rises;
    repeat (100) begin
      @(negedge clk);
      if (scl !== 1'b1) break;
    end
    chk(scl === 1'b1 && scl_rises == r0, "R10 scl parked high", scl_rises - r0, 0);
  endtask

  task automatic t_bad_codes();
    logic [3:0] bad [10] = '{4'h2, 4'h4, 4'h7, 4'h8, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    int i0, s0, p0, r0;
    for (int k = 0; k < 10; k++) begin
      i0 = irq_cnt; s0 = start_cnt; p0 = stop_cnt; r0 = scl_rises;
      put_cmd(bad[k]);
      repeat (20) @(negedge clk);
      chk(ctl_rdata[7:6] == 2'b10, "R9 error set, not busy", ctl_rdata[7:6], 2'b10);
      chk(irq_cnt == i0 && start_cnt == s0 && stop_cnt == p0 && scl_rises == r0 &&
          scl === 1'b1, "R9 no bus activity", irq_cnt - i0 + scl_rises - r0, 0);
      put_cmd(4'b0000);
      chk(ctl_rdata[7] == 1'b0, "R9 cleared by idle", ctl_rdata[7], 0);
    end
    put_cmd(4'hD);
    put_cmd(4'b1001);
    chk(ctl_rdata[7] == 1'b0, "R9 cleared by start", ctl_rdata[7], 0);
    settle();
    put_cmd(4'b0000);
  endtask

  task automatic t_busy_ignore();
    logic [8:0] got;
    int p0, i0;
    put_data(8'h5A);
    p0 = stop_cnt; i0 = irq_cnt;
    put_cmd(4'b0011);
    fork
      respond(1'b0, 8'h00, 1'b1, got);
      begin
        repeat (30) @(negedge clk);
        put_cmd(4'b0101);
        put_cmd(4'b0010);
        put_data(8'hFF);
      end
    join
    settle();
    repeat (60) @(negedge clk);
    chk(got[8:1] == 8'h5A, "R11 byte unchanged", got[8:1], 8'h5A);
    chk(dat_rdata == 8'h5A, "R11 data write ignored", dat_rdata, 8'h5A);
    chk(ctl_rdata[7:6] == 2'b00 && irq_cnt - i0 == 1 && stop_cnt == p0,
        "R11 commands ignored", {ctl_rdata[7:6], irq_cnt - i0}, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_parked();
    t_write(8'hA5, 1'b1);
    t_write(8'h3C, 1'b0);
    t_read(8'h96, 1'b0);
    t_read(8'h4B, 1'b1);
    t_stop();
    t_clock_modes();
    t_bad_codes();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule